// File: doc/BRIEF.md
# DDR Two-Cycle Address/Command Launcher

This block sits between a memory controller and the address/command pins of a DDR SDRAM. The controller hands over one command at a time: a type code, a bank, an address, and the clock-enable and termination levels it wants. The block then drives that command onto the bus with two-cycle timing. The command lines, bank and address are launched together and held for a whole slot, so they have a full extra cycle to settle. Chip select, clock enable and on-die termination move only in the last cycle of the slot. That qualifying cycle is the only one in which the memory samples the command.

Slots follow one another with no gap, so a stream of reads or writes leaves at one command per slot. Chip select then pulses low in every other cycle. A ready/valid handshake tells the controller when a new slot is about to begin. A slot with no request carries a no-operation code with chip select high. All outputs come straight from flops clocked on the rising edge of the double-rate address/command clock.

Top module: `ddr2t_cmd_launcher`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `mem_cs_n`, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are 1, `mem_cke` and `mem_odt` are 0, `mem_ba` and `mem_addr` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only in the last cycle of each slot. A request is accepted at a rising edge where both `req_valid` and `req_ready` are 1, and `req_ready` is 0 in the cycle after an accepting edge.
- R3: The `req_cmd` code selects the active-low command lines (`mem_ras_n`, `mem_cas_n`, `mem_we_n`) as follows: 0 = no-op (1,1,1), 1 = activate (0,1,1), 2 = read (1,0,1), 3 = write (1,0,0), 4 = precharge (0,1,0). Codes 5 to 7 drive the no-op pattern.
- R4: The command lines, `mem_ba` and `mem_addr` change on the accepting edge and hold their values through both cycles of the slot.
- R5: `mem_cs_n` is 1 in the first cycle of every slot. It is 0 in the second cycle exactly when the slot carries an accepted request, including a no-op or unknown code.
- R6: `req_cke` and `req_odt` are sampled at every slot-start edge and appear on `mem_cke` and `mem_odt` from the second cycle of that slot onward. These outputs never change at any other edge.
- R7: A slot that starts without a request drives the no-op pattern, keeps `mem_cs_n` at 1, and leaves `mem_ba` and `mem_addr` at their previous values.
- R8: Back-to-back requests go out in consecutive slots with no empty cycle. Chip select is low in every other cycle, and an incrementing address stream (0x0, 0x4, 0x8, 0xC, 0x10) appears with one new value every two cycles.
- R9: Request inputs presented while `req_ready` is 0 (command, bank, address, clock-enable and termination) have no effect on any output.
- R10: Reset asserted in the middle of a slot returns every output and `req_ready` to the levels of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate address/command clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is offered |
| req_ready | output | 1 | The next edge starts a slot and can accept a command |
| req_cmd | input | 3 | Command type code (see R3) |
| req_bank | input | BA_W (3) | Target bank |
| req_addr | input | A_W (14) | Row or column address |
| req_cke | input | 1 | Requested clock-enable level |
| req_odt | input | 1 | Requested on-die-termination level |
| mem_cs_n | output | 1 | Chip select, active low, low only in the qualifying cycle |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W (3) | Bank address |
| mem_addr | output | A_W (14) | Address bus |
| mem_cke | output | 1 | Clock enable to memory |
| mem_odt | output | 1 | On-die termination enable |

## Verification
Every cycle, the assertions check four things. Chip select never stays low for two cycles in a row. Bank, address and command lines are unchanged in any cycle where chip select is low. Those lines move only on a slot-start edge, and clock enable and termination move only on a qualifying edge. An accepted request is always followed by a busy, deselected cycle. The exact encoding of each command code needs the bench's scenarios, and so do the rule that idle slots keep the old address, the ignoring of requests offered while busy, and the sequence precharge, activate, then a run of writes with stepping addresses.

// File: rtl/ddr2t_pkg.sv
package ddr2t_pkg;

    // Request type codes presented on req_cmd
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } op_e;

    // Active-low strobe bundle driven to the memory
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Map a request code onto the strobe pattern; unknown codes become no-op
    function automatic strobe_t op_to_strobe(input logic [2:0] code);
        strobe_t s;
        s = STROBE_IDLE;
        case (code)
            OP_ACT: s.ras_n = 1'b0;
            OP_RD:  s.cas_n = 1'b0;
            OP_WR:  begin s.cas_n = 1'b0; s.we_n = 1'b0; end
            OP_PRE: begin s.ras_n = 1'b0; s.we_n = 1'b0; end
            default: s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr2t_slot_timer.sv
module ddr2t_slot_timer #(
    parameter int SLOT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic slot_open,   // next edge begins a slot
    output logic slot_qual    // next edge enters the qualifying cycle
);
    localparam int CW   = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
    localparam int LAST = SLOT_CYCLES - 1;

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (pos_q == CW'(LAST)) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + CW'(1);
        end
    end

    assign slot_open = (pos_q == '0);
    assign slot_qual = (pos_q == CW'(LAST));

endmodule

// File: rtl/ddr2t_op_decode.sv
module ddr2t_op_decode
    import ddr2t_pkg::*;
(
    input  logic [2:0] op_code,
    output strobe_t    strobe
);
    always_comb begin
        strobe = op_to_strobe(op_code);
    end

    // R3
    always_comb begin
        if (!$isunknown(op_code)) begin
            ras_cas_excl_chk: assert (strobe.ras_n || strobe.cas_n)
                else $error("row and column strobes both low");
        end
    end

endmodule

// File: rtl/ddr2t_ac_stage.sv
module ddr2t_ac_stage
    import ddr2t_pkg::*;
#(
    parameter int A_W  = 14,
    parameter int BA_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_open,
    input  logic            slot_qual,
    input  logic            take,
    input  strobe_t         strobe_in,
    input  logic [BA_W-1:0] bank_in,
    input  logic [A_W-1:0]  addr_in,
    input  logic            cke_in,
    input  logic            odt_in,
    output strobe_t         strobe_q,
    output logic [BA_W-1:0] bank_q,
    output logic [A_W-1:0]  addr_q,
    output logic            cs_n_q,
    output logic            cke_q,
    output logic            odt_q
);
    logic sel_pend_q;
    logic cke_pend_q;
    logic odt_pend_q;
    logic hist_ok_q;

    // Launch stage: strobes, bank and address held for the whole slot
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q   <= STROBE_IDLE;
            bank_q     <= '0;
            addr_q     <= '0;
            sel_pend_q <= 1'b0;
            cke_pend_q <= 1'b0;
            odt_pend_q <= 1'b0;
        end else if (slot_open) begin
            cke_pend_q <= cke_in;
            odt_pend_q <= odt_in;
            sel_pend_q <= take;
            if (take) begin
                strobe_q <= strobe_in;
                bank_q   <= bank_in;
                addr_q   <= addr_in;
            end else begin
                strobe_q <= STROBE_IDLE;
            end
        end
    end

    // Qualify stage: select, clock enable and termination in the last cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
            cke_q  <= 1'b0;
            odt_q  <= 1'b0;
        end else if (slot_qual) begin
            cs_n_q <= ~sel_pend_q;
            cke_q  <= cke_pend_q;
            odt_q  <= odt_pend_q;
        end else begin
            cs_n_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_ok_q <= 1'b0;
        else     hist_ok_q <= 1'b1;
    end

    // R5
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n_q |=> cs_n_q)
        else $error("select low in two consecutive cycles");

    // R4
    hold_under_cs_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok_q)
        !cs_n_q |-> $stable({strobe_q, bank_q, addr_q}))
        else $error("bus moved during qualifying cycle");

    // R4
    launch_edge_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok_q)
        !$stable({strobe_q, bank_q, addr_q}) |-> $past(slot_open))
        else $error("bus moved away from slot start");

    // R6
    cke_odt_edge_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok_q)
        !$stable({cke_q, odt_q}) |-> $past(slot_qual))
        else $error("clock enable or termination moved outside qualifying edge");

endmodule

// File: rtl/ddr2t_cmd_launcher.sv
module ddr2t_cmd_launcher
    import ddr2t_pkg::*;
#(
    parameter int A_W         = 14,
    parameter int BA_W        = 3,
    parameter int SLOT_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_cmd,
    input  logic [BA_W-1:0] req_bank,
    input  logic [A_W-1:0]  req_addr,
    input  logic            req_cke,
    input  logic            req_odt,
    output logic            mem_cs_n,
    output logic            mem_ras_n,
    output logic            mem_cas_n,
    output logic            mem_we_n,
    output logic [BA_W-1:0] mem_ba,
    output logic [A_W-1:0]  mem_addr,
    output logic            mem_cke,
    output logic            mem_odt
);
    logic    slot_open;
    logic    slot_qual;
    logic    take;
    strobe_t dec_strobe;
    strobe_t bus_strobe;

    ddr2t_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_open (slot_open),
        .slot_qual (slot_qual)
    );

    ddr2t_op_decode u_decode (
        .op_code (req_cmd),
        .strobe  (dec_strobe)
    );

    assign req_ready = slot_open;
    assign take      = req_valid & slot_open;

    ddr2t_ac_stage #(.A_W(A_W), .BA_W(BA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .slot_open (slot_open),
        .slot_qual (slot_qual),
        .take      (take),
        .strobe_in (dec_strobe),
        .bank_in   (req_bank),
        .addr_in   (req_addr),
        .cke_in    (req_cke),
        .odt_in    (req_odt),
        .strobe_q  (bus_strobe),
        .bank_q    (mem_ba),
        .addr_q    (mem_addr),
        .cs_n_q    (mem_cs_n),
        .cke_q     (mem_cke),
        .odt_q     (mem_odt)
    );

    assign mem_ras_n = bus_strobe.ras_n;
    assign mem_cas_n = bus_strobe.cas_n;
    assign mem_we_n  = bus_strobe.we_n;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && mem_cs_n))
        else $error("slot not busy after accept");

endmodule

// File: tb/ddr2t_cmd_launcher_tb.sv
module ddr2t_cmd_launcher_tb;
    localparam int CLK_PERIOD = 10;
    localparam int A_W  = 14;
    localparam int BA_W = 3;

    typedef struct packed {
        logic            v;
        logic [2:0]      cmd;
        logic [BA_W-1:0] ba;
        logic [A_W-1:0]  addr;
        logic            cke;
        logic            odt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 3'd0, 14'h0000, 1'b1, 1'b0},  // idle slot
        '{1'b1, 3'd0, 3'd0, 14'h0000, 1'b1, 1'b0},  // explicit no-op
        '{1'b1, 3'd4, 3'd0, 14'h0400, 1'b1, 1'b0},  // precharge
        '{1'b1, 3'd1, 3'd1, 14'h0001, 1'b1, 1'b0},  // activate
        '{1'b1, 3'd3, 3'd1, 14'h0000, 1'b1, 1'b1},  // writes, stepping address
        '{1'b1, 3'd3, 3'd1, 14'h0004, 1'b1, 1'b1},
        '{1'b1, 3'd3, 3'd1, 14'h0008, 1'b1, 1'b1},
        '{1'b1, 3'd3, 3'd1, 14'h000C, 1'b1, 1'b1},
        '{1'b1, 3'd3, 3'd1, 14'h0010, 1'b1, 1'b1},
        '{1'b1, 3'd2, 3'd1, 14'h0020, 1'b1, 1'b0},  // read
        '{1'b0, 3'd3, 3'd5, 14'h1234, 1'b1, 1'b0},  // idle, junk on bus inputs
        '{1'b1, 3'd7, 3'd2, 14'h0033, 1'b1, 1'b0},  // unknown code
        '{1'b1, 3'd1, 3'd3, 14'h3FFF, 1'b0, 1'b1},  // activate, cke drop
        '{1'b0, 3'd0, 3'd0, 14'h0000, 1'b0, 1'b0}   // idle
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [2:0]      req_cmd = '0;
    logic [BA_W-1:0] req_bank = '0;
    logic [A_W-1:0]  req_addr = '0;
    logic            req_cke = 1'b0;
    logic            req_odt = 1'b0;
    logic            mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [BA_W-1:0] mem_ba;
    logic [A_W-1:0]  mem_addr;
    logic            mem_cke, mem_odt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr2t_cmd_launcher #(.A_W(A_W), .BA_W(BA_W), .SLOT_CYCLES(2)) u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_cmd (req_cmd), .req_bank (req_bank), .req_addr (req_addr),
        .req_cke (req_cke), .req_odt (req_odt),
        .mem_cs_n (mem_cs_n), .mem_ras_n (mem_ras_n), .mem_cas_n (mem_cas_n),
        .mem_we_n (mem_we_n), .mem_ba (mem_ba), .mem_addr (mem_addr),
        .mem_cke (mem_cke), .mem_odt (mem_odt)
    );

    function automatic logic [2:0] exp_lines(input logic [2:0] code);
        case (code)
            3'd1:    return 3'b011;
            3'd2:    return 3'b101;
            3'd3:    return 3'b100;
            3'd4:    return 3'b010;
            default: return 3'b111;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_idle_state(input string tag);
        chk(tag, "cs_n", 32'(mem_cs_n), 32'd1);
        chk(tag, "lines", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'h7);
        chk(tag, "cke", 32'(mem_cke), 32'd0);
        chk(tag, "odt", 32'(mem_odt), 32'd0);
        chk(tag, "ba", 32'(mem_ba), 32'd0);
        chk(tag, "addr", 32'(mem_addr), 32'd0);
        chk(tag, "ready", 32'(req_ready), 32'd1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [A_W-1:0]  e_addr;
        logic [BA_W-1:0] e_ba;
        logic [2:0]      e_lines;
        logic            e_cke, e_odt;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle_state("R1");           // during reset
        rst = 1'b0;
        chk_idle_state("R1");           // first cycle after release

        e_addr = '0; e_ba = '0; e_cke = 1'b0; e_odt = 1'b0;
        for (int i = 0; i < NV; i++) begin
            chk("R2", "ready at slot start", 32'(req_ready), 32'd1);
            req_valid = VECS[i].v;
            req_cmd   = VECS[i].cmd;
            req_bank  = VECS[i].ba;
            req_addr  = VECS[i].addr;
            req_cke   = VECS[i].cke;
            req_odt   = VECS[i].odt;
            if (VECS[i].v) begin
                e_lines = exp_lines(VECS[i].cmd);
                e_addr  = VECS[i].addr;
                e_ba    = VECS[i].ba;
            end else begin
                e_lines = 3'b111;
            end
            @(posedge clk);
            @(negedge clk);
            // first cycle of the slot
            chk("R2", "ready in first cycle", 32'(req_ready), 32'd0);
            chk("R5", "cs_n first cycle", 32'(mem_cs_n), 32'd1);
            chk("R3", "lines first cycle", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'(e_lines));
            chk("R4", "addr first cycle", 32'(mem_addr), 32'(e_addr));
            chk("R7", "ba first cycle", 32'(mem_ba), 32'(e_ba));
            chk("R6", "cke unchanged in first cycle", 32'(mem_cke), 32'(e_cke));
            chk("R6", "odt unchanged in first cycle", 32'(mem_odt), 32'(e_odt));
            // R9: junk offered while busy
            req_valid = 1'b1;
            req_cmd   = 3'd3;
            req_bank  = '1;
            req_addr  = 14'h2AAA;
            req_cke   = ~VECS[i].cke;
            req_odt   = ~VECS[i].odt;
            e_cke = VECS[i].cke;
            e_odt = VECS[i].odt;
            @(posedge clk);
            @(negedge clk);
            // second (qualifying) cycle
            chk(VECS[i].v ? "R8" : "R7", "cs_n second cycle",
                32'(mem_cs_n), VECS[i].v ? 32'd0 : 32'd1);
            chk("R4", "lines held", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'(e_lines));
            chk("R8", "addr held", 32'(mem_addr), 32'(e_addr));
            chk("R9", "ba unaffected by busy request", 32'(mem_ba), 32'(e_ba));
            chk("R6", "cke in second cycle", 32'(mem_cke), 32'(e_cke));
            chk("R9", "odt unaffected by busy request", 32'(mem_odt), 32'(e_odt));
            chk("R2", "ready in last cycle", 32'(req_ready), 32'd1);
        end

        // R10: reset in the middle of a slot
        req_valid = 1'b1; req_cmd = 3'd3; req_bank = 3'd6;
        req_addr = 14'h0ABC; req_cke = 1'b1; req_odt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "write launched before reset", 32'(mem_addr), 32'h0ABC);
        rst = 1'b1;
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_idle_state("R10");
        @(posedge clk);
        @(negedge clk);
        chk("R10", "no select after reset", 32'(mem_cs_n), 32'd1);

        done = 1'b1;
        finish_run();
    end

endmodule